// File: doc/BRIEF.md
# Segmented TLP Stream Protocol Checker

This block is a passive observer placed beside a transmit stream that moves transaction-layer packets over a wide bus. The bus is cut into parallel 256-bit segments, and the segment count is a parameter from 1 to 4. Every segment has its own data lane and its own header lane. Each segment also has a header-valid flag and an end-of-packet flag. A valid/ready handshake with zero ready latency moves the stream forward. The checker only reads these signals and never drives any of them.

On each clock the checker tests the observed beat against a set of framing, byte-enable and handshake rules. For each violation it raises a one-cycle pulse with a 4-bit code. It also sets a sticky flag for each violated rule, and only reset clears these flags. Integrators place it beside the producer of the stream, or in a bench, so that a protocol slip is caught at the cycle where it happens.

Top module: `tlp_seg_checker`

## Requirements
- R1: A transfer happens only on a clock edge where `s_valid` and `s_ready` are both 1. On any other edge, the keep, framing and header-count rules raise nothing and the open-packet state stays as it was.
- R2: If a transfer has more than two bits of `s_seg_hv` set, code 1 is reported.
- R3: If a transfer has `s_last` = 0 and any bit of `s_keep` = 0, code 2 is reported.
- R4: If a transfer has `s_last` = 1, the set bits of `s_keep` must form one run that starts at byte 0, so that keep & (keep+1) = 0. All-zero keep is allowed. Any other pattern reports code 3.
- R5: Suppose an edge sees `s_valid` = 1 and `s_ready` = 0. If the next edge sees `s_valid` = 0, or any change in data, keep, last, header-valid, segment-end or header, code 4 is reported.
- R6: Within a transfer, segments are scanned from index 0 upward. At each segment a header-valid bit is handled first, then its segment-end bit. A header-valid bit that arrives while a packet is still open reports code 5 and starts a new packet.
- R7: A segment-end bit that arrives with no open packet reports code 6. A header-valid bit and a segment-end bit in the same segment form a legal header-only packet.
- R8: A violation on the transfer at clock edge k drives `err_pulse` = 1 and `err_code` for exactly the cycle after edge k. When several rules fail together, the lowest code is reported. With no violation, `err_pulse` = 0 and `err_code` = 0.
- R9: Every violation found at an edge sets bit (code-1) of `err_flags`, including violations that lose the priority choice. These bits stay set until reset.
- R10: While `rst_n` is low, and right after it is released, `err_pulse`, `err_code` and `err_flags` are all zero and no packet is open.
- R11: The open-packet state carries across transfers, so a packet may start on one beat and end on a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized to clk |
| s_valid | input | 1 | Source has a beat on the bus |
| s_ready | input | 1 | Sink accepts the beat |
| s_data | input | NSEG*256 | Data lanes |
| s_keep | input | NSEG*32 | One byte-enable per data byte |
| s_last | input | 1 | Final beat of the transmission |
| s_seg_hv | input | NSEG | Header lane of each segment is valid |
| s_seg_end | input | NSEG | Packet ends in this segment |
| s_hdr | input | NSEG*256 | Header lanes |
| err_pulse | output | 1 | One-cycle violation strobe |
| err_code | output | 4 | Code of the highest-priority violation (0 when none) |
| err_flags | output | 6 | Sticky violation flags, bit n for code n+1 |

## Verification
The embedded properties are checked every cycle. They cover the header-count limit reaching the sticky flags, the rule that sticky flags never clear outside reset, the agreement between the pulse and the code, the absence of a stall error when a stalled beat is held steady, and header-only packets on a closed stream never raising a framing error. The bench scenarios are needed for the rest. They show the exact code chosen when several rules fail at once, the carry of the open-packet state across beats and across idle cycles, and each injected violation producing its code on the following cycle. A randomly framed stream is compared against a bench model of the framing walk.

// File: rtl/tlpchk_pkg.sv
package tlpchk_pkg;

  localparam int unsigned SEG_BITS = 256;
  localparam int unsigned NUM_ERR  = 6;

  typedef enum logic [3:0] {
    ERR_NONE        = 4'd0,
    ERR_HDR_COUNT   = 4'd1,
    ERR_KEEP_HOLE   = 4'd2,
    ERR_KEEP_SPARSE = 4'd3,
    ERR_STALL_MOVE  = 4'd4,
    ERR_HDR_IN_PKT  = 4'd5,
    ERR_ORPHAN_END  = 4'd6
  } err_code_e;

  // Lowest violated rule wins: bit n of the mask maps to code n+1.
  function automatic err_code_e pick_code(input logic [NUM_ERR-1:0] mask);
    err_code_e c;
    c = ERR_NONE;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (mask[i]) c = err_code_e'(4'(i + 1));
    end
    return c;
  endfunction

endpackage

// File: rtl/seg_frame_tracker.sv
module seg_frame_tracker #(
  parameter int unsigned NSEG    = 4,
  parameter int unsigned MAX_HDR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer,
  input  logic [NSEG-1:0] hv,
  input  logic [NSEG-1:0] sl,
  output logic            too_many_hdr,
  output logic            hdr_in_pkt,
  output logic            orphan_end
);

  localparam int unsigned CNT_W = $clog2(NSEG + 1);

  logic [NSEG:0]   open_chain;
  logic [NSEG-1:0] hdr_clash;
  logic [NSEG-1:0] end_lonely;
  logic [CNT_W-1:0] hdr_cnt;
  logic            open_q;
  logic            open_d;

  assign open_chain[0] = open_q;

  // Ordered walk across segments: header first, then end flag.
  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_seg
      logic after_hdr;
      assign after_hdr         = hv[g] | open_chain[g];
      assign hdr_clash[g]      = hv[g] & open_chain[g];
      assign end_lonely[g]     = sl[g] & ~after_hdr;
      assign open_chain[g + 1] = after_hdr & ~sl[g];
    end
  endgenerate

  always_comb begin
    hdr_cnt = '0;
    for (int i = 0; i < NSEG; i++) begin
      hdr_cnt = hdr_cnt + CNT_W'(hv[i]);
    end
  end

  assign too_many_hdr = xfer & ({{(32 - CNT_W){1'b0}}, hdr_cnt} > MAX_HDR);
  assign hdr_in_pkt   = xfer & (|hdr_clash);
  assign orphan_end   = xfer & (|end_lonely);

  always_comb begin
    open_d = open_q;
    if (xfer) open_d = open_chain[NSEG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  AST_OPEN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(open_q)); // R1

  AST_HDR_ONLY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !open_q && (hv == sl)) |-> (!hdr_in_pkt && !orphan_end)); // R7

endmodule

// File: rtl/keep_rule_check.sv
module keep_rule_check #(
  parameter int unsigned KW = 128
) (
  input  logic          xfer,
  input  logic          last,
  input  logic [KW-1:0] keep,
  output logic          hole_err,
  output logic          sparse_err
);

  logic [KW-1:0] keep_inc;
  logic          run_from_zero;

  assign keep_inc      = keep + KW'(1);
  assign run_from_zero = ((keep & keep_inc) == '0);

  assign hole_err   = xfer & ~last & ~(&keep);
  assign sparse_err = xfer & last & ~run_from_zero;

endmodule

// File: rtl/stall_hold_monitor.sv
module stall_hold_monitor #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic         ready,
  input  logic [W-1:0] bundle,
  output logic         move_err
);

  logic         stall_q, stall_d;
  logic [W-1:0] snap_q, snap_d;
  logic         snap_en;

  assign snap_en = valid & ~ready;

  always_comb begin
    stall_d = snap_en;
    snap_d  = snap_q;
    if (snap_en) snap_d = bundle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      stall_q <= stall_d;
      snap_q  <= snap_d;
    end
  end

  assign move_err = stall_q & (~valid | (bundle != snap_q));

  AST_STALL_STEADY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(valid && !ready) && valid && $stable(bundle)) |-> !move_err); // R5

endmodule

// File: rtl/tlp_seg_checker.sv
module tlp_seg_checker
  import tlpchk_pkg::*;
#(
  parameter int unsigned NSEG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  input  logic                     s_ready,
  input  logic [NSEG*SEG_BITS-1:0] s_data,
  input  logic [NSEG*SEG_BITS/8-1:0] s_keep,
  input  logic                     s_last,
  input  logic [NSEG-1:0]          s_seg_hv,
  input  logic [NSEG-1:0]          s_seg_end,
  input  logic [NSEG*SEG_BITS-1:0] s_hdr,
  output logic                     err_pulse,
  output logic [3:0]               err_code,
  output logic [NUM_ERR-1:0]       err_flags
);

  localparam int unsigned DW    = NSEG * SEG_BITS;
  localparam int unsigned KW    = DW / 8;
  localparam int unsigned HOLDW = 2 * DW + KW + 1 + 2 * NSEG;

  logic xfer;
  logic too_many_hdr, hdr_in_pkt, orphan_end;
  logic hole_err, sparse_err, move_err;
  logic [NUM_ERR-1:0] viol;

  logic               pulse_q, pulse_d;
  err_code_e          code_q, code_d;
  logic [NUM_ERR-1:0] flags_q, flags_d;

  assign xfer = s_valid & s_ready;

  seg_frame_tracker #(.NSEG(NSEG), .MAX_HDR(2)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer         (xfer),
    .hv           (s_seg_hv),
    .sl           (s_seg_end),
    .too_many_hdr (too_many_hdr),
    .hdr_in_pkt   (hdr_in_pkt),
    .orphan_end   (orphan_end)
  );

  keep_rule_check #(.KW(KW)) u_keep (
    .xfer       (xfer),
    .last       (s_last),
    .keep       (s_keep),
    .hole_err   (hole_err),
    .sparse_err (sparse_err)
  );

  stall_hold_monitor #(.W(HOLDW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (s_valid),
    .ready    (s_ready),
    .bundle   ({s_data, s_hdr, s_keep, s_last, s_seg_hv, s_seg_end}),
    .move_err (move_err)
  );

  assign viol = {orphan_end, hdr_in_pkt, move_err, sparse_err, hole_err, too_many_hdr};

  always_comb begin
    pulse_d = |viol;
    code_d  = pick_code(viol);
    flags_d = flags_q | viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      code_q  <= ERR_NONE;
      flags_q <= '0;
    end else begin
      pulse_q <= pulse_d;
      code_q  <= code_d;
      flags_q <= flags_d;
    end
  end

  assign err_pulse = pulse_q;
  assign err_code  = code_q;
  assign err_flags = flags_q;

  AST_HDR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && ($countones(s_seg_hv) > 2)) |=> err_flags[0]); // R2

  AST_FULL_KEEP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && (&s_keep)) |-> (!hole_err && !sparse_err)); // R3

  AST_PULSE_CODE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse == (err_code != 4'd0)); // R8

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_code <= 4'(NUM_ERR)); // R8

  genvar f;
  generate
    for (f = 0; f < NUM_ERR; f++) begin : g_flag_chk
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_flags[f]) |-> err_flags[f]); // R9
    end
  endgenerate

endmodule

// File: tb/tlp_seg_checker_bench.sv
`timescale 1ns/1ps
module tlp_seg_checker_bench;

  localparam int unsigned NSEG = 4;
  localparam int unsigned DW   = NSEG * 256;
  localparam int unsigned KW   = DW / 8;
  localparam int unsigned NE   = 6;

  logic            clk;
  logic            rst_n;
  logic            s_valid, s_ready, s_last;
  logic [DW-1:0]   s_data, s_hdr;
  logic [KW-1:0]   s_keep;
  logic [NSEG-1:0] s_seg_hv, s_seg_end;
  logic            err_pulse;
  logic [3:0]      err_code;
  logic [NE-1:0]   err_flags;

  int n_chk;
  int n_fail;
  bit done;

  tlp_seg_checker #(.NSEG(NSEG)) u_tlp_seg_checker (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_keep(s_keep), .s_last(s_last), .s_seg_hv(s_seg_hv),
    .s_seg_end(s_seg_end), .s_hdr(s_hdr), .err_pulse(err_pulse),
    .err_code(err_code), .err_flags(err_flags)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_wide();
    logic [DW-1:0] v;
    for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  // Bench model of the rules: bit n of the result is code n+1.
  function automatic logic [NE-1:0] model(input logic open_in, input logic [NSEG-1:0] hv,
      input logic [NSEG-1:0] sl, input logic [KW-1:0] keep, input logic last,
      output logic open_out);
    logic [NE-1:0] m;
    logic o;
    int n;
    m = '0; n = 0; o = open_in;
    for (int i = 0; i < NSEG; i++) n += int'(hv[i]);
    if (n > 2) m[0] = 1'b1;
    if (!last && (keep != '1)) m[1] = 1'b1;
    if (last && ((keep & (keep + KW'(1))) != '0)) m[2] = 1'b1;
    for (int i = 0; i < NSEG; i++) begin
      if (hv[i]) begin
        if (o) m[4] = 1'b1;
        o = 1'b1;
      end
      if (sl[i]) begin
        if (!o) m[5] = 1'b1;
        o = 1'b0;
      end
    end
    open_out = o;
    return m;
  endfunction

  function automatic logic [3:0] lowest(input logic [NE-1:0] m);
    logic [3:0] c;
    c = 4'd0;
    for (int i = NE - 1; i >= 0; i--) if (m[i]) c = 4'(i + 1);
    return c;
  endfunction

  task automatic put(input logic v, input logic r, input logic [NSEG-1:0] hv,
      input logic [NSEG-1:0] sl, input logic [KW-1:0] keep, input logic last);
    s_valid = v; s_ready = r; s_seg_hv = hv; s_seg_end = sl; s_keep = keep; s_last = last;
    s_data = rnd_wide(); s_hdr = rnd_wide();
    @(negedge clk);
  endtask

  task automatic idle();
    s_valid = 1'b0; s_ready = 1'b1; s_seg_hv = '0; s_seg_end = '0; s_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    s_valid = 1'b0; s_ready = 1'b0; s_seg_hv = '0; s_seg_end = '0;
    s_keep = '0; s_last = 1'b0; s_data = '0; s_hdr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  localparam logic [KW-1:0] FULL = '1;

  initial begin
    logic open_m, open_n;
    logic [NE-1:0] m, acc;
    logic [KW-1:0] k;
    n_chk = 0; n_fail = 0; done = 0;
    void'($urandom(32'd1234));

    // R10: reset values
    do_reset();
    chk("R10 pulse after reset", 32'(err_pulse), 0);
    chk("R10 code after reset", 32'(err_code), 0);
    chk("R10 flags after reset", 32'(err_flags), 0);

    // R7/R11: two packets in one beat, second is header-only
    put(1, 1, 4'b0101, 4'b0110, FULL, 1);
    chk("R7 dual packet beat with header-only", 32'(err_code), 0);
    // R11: packet spanning two beats, partial contiguous keep on last
    put(1, 1, 4'b0001, 4'b0000, FULL, 0);
    chk("R11 open beat", 32'(err_code), 0);
    put(1, 1, 4'b0000, 4'b1000, FULL >> 7, 1);
    chk("R11 close on later beat (R4 legal run)", 32'(err_code), 0);

    // R2: three headers
    put(1, 1, 4'b0111, 4'b0111, FULL, 1);
    chk("R2 three headers code", 32'(err_code), 1);
    chk("R8 pulse with code", 32'(err_pulse), 1);
    idle();
    chk("R8 pulse lasts one cycle", 32'(err_pulse), 0);

    // R3: hole on a non-last beat
    put(1, 1, 4'b0001, 4'b0000, FULL & ~(KW'(1) << 5), 0);
    chk("R3 keep hole code", 32'(err_code), 2);
    put(1, 1, 4'b0000, 4'b0001, FULL, 1);
    chk("R11 close after hole beat", 32'(err_code), 0);

    // R4: sparse keep on last beat
    put(1, 1, 4'b0001, 4'b0001, KW'(8'hF0), 1);
    chk("R4 sparse keep code", 32'(err_code), 3);

    // R6: header while open
    put(1, 1, 4'b0001, 4'b0000, FULL, 0);
    chk("R6 opening beat", 32'(err_code), 0);
    put(1, 1, 4'b0010, 4'b0010, FULL, 1);
    chk("R6 header in open packet code", 32'(err_code), 5);

    // R7: end with no open packet
    put(1, 1, 4'b0000, 4'b0001, FULL, 1);
    chk("R7 orphan end code", 32'(err_code), 6);

    // R1: non-transfer beats carry illegal framing but raise nothing
    put(0, 1, 4'b1111, 4'b1111, '0, 0);
    chk("R1 valid low ignored", 32'(err_code), 0);
    put(0, 0, 4'b0000, 4'b0001, '0, 0);
    chk("R1 valid and ready low ignored", 32'(err_code), 0);
    put(1, 1, 4'b0001, 4'b0001, FULL, 1);
    chk("R1 state unchanged by idle beats", 32'(err_code), 0);

    // R5: stall, hold steady, then change
    s_valid = 1; s_ready = 0; s_seg_hv = 4'b0001; s_seg_end = 4'b0001; s_keep = FULL; s_last = 1;
    s_data = rnd_wide(); s_hdr = rnd_wide();
    @(negedge clk);
    chk("R5 first stall cycle", 32'(err_code), 0);
    @(negedge clk);
    chk("R5 steady stall", 32'(err_code), 0);
    s_data[7] = ~s_data[7]; s_ready = 1;
    @(negedge clk);
    chk("R5 data moved during stall", 32'(err_code), 4);
    put(1, 0, 4'b0001, 4'b0001, FULL, 1);
    idle();
    chk("R5 valid dropped during stall", 32'(err_code), 4);

    // R8/R9: several rules at once after a fresh reset
    do_reset();
    put(1, 1, 4'b1111, 4'b0000, KW'(8'hF0), 1);
    chk("R8 lowest code wins", 32'(err_code), 1);
    chk("R9 all violated rules flagged", 32'(err_flags), 32'b010101);
    idle();
    chk("R9 flags stay set", 32'(err_flags), 32'b010101);

    // Random framing against the bench model
    do_reset();
    open_m = 1'b0; acc = '0;
    for (int t = 0; t < 400; t++) begin
      logic [NSEG-1:0] hv, sl;
      logic v, last;
      v    = ($urandom_range(0, 7) != 0);
      hv   = NSEG'($urandom()) & NSEG'($urandom());
      sl   = NSEG'($urandom()) & NSEG'($urandom());
      last = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 3))
        0: k = FULL;
        1: k = FULL >> $urandom_range(0, KW - 1);
        2: k = FULL & ~(KW'(1) << $urandom_range(0, KW - 2));
        default: k = '0;
      endcase
      if (v) begin
        m = model(open_m, hv, sl, k, last, open_n);
        open_m = open_n;
      end else begin
        m = '0;
      end
      acc |= m;
      put(v, 1, hv, sl, k, last);
      chk("R2 R3 R4 R6 R7 random beat code", 32'(err_code), 32'(lowest(m)));
    end
    chk("R9 random sticky flags", 32'(err_flags), 32'(acc));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule